// File: doc/BRIEF.md
# Serial Audio Input Receiver

This block takes a stereo PCM stream carried on three wires (a bit clock, a channel-select clock and a serial data line) and turns it into parallel sample words inside the system clock domain. The system clock must be faster than the bit clock. All three wires pass through synchronizers. The receiver follows the bit clock by detecting its rising edges, and it recovers one left word and one right word per sample period. When a frame is complete, both words appear together with a one-cycle valid strobe.

Three static controls select the framing. The first picks right-justified or I2S framing. The second picks a 16-bit or 18-bit word length. The third picks which level of the channel-select line means left. In right-justified framing the word ends on the last bit before the channel-select edge. In I2S framing the word starts one bit period after that edge. A 16-bit word is sign-extended to the 18-bit output width. The controls are expected to change only while the block is held in reset.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_left` and `out_right` are 0. The half-frame that is running when the first channel-select change after reset arrives is discarded. No valid pulse appears until a left word and then a right word have been captured after that change.
- R2: Data is taken MSB first, one bit for each rising edge of `sdi_bclk`. A bit whose data level is held for the whole high phase of `sdi_bclk` is taken with that level. The high and low phases of `sdi_bclk` each last at least 2 system clock periods.
- R3: When `cfg_len18` is 0, a word is 16 bits long and bit 15 is copied into output bits 17:16. When `cfg_len18` is 1, a word is 18 bits long and is presented as received.
- R4: When `cfg_lr_inv` is 0, a high `sdi_lrck` marks left data and a low `sdi_lrck` marks right data. When `cfg_lr_inv` is 1, this mapping is reversed.
- R5: When `cfg_i2s` is 0 (right-justified), the word's LSB is the last bit taken before a change of `sdi_lrck`. Any bits of a half-frame that come before the word's MSB are discarded.
- R6: When `cfg_i2s` is 1 (I2S), the MSB is the second bit taken after a change of `sdi_lrck`. Bits after the LSB are ignored. When the half-frame holds exactly one word, the LSB is the first bit taken after the next change of `sdi_lrck`.
- R7: `out_valid` is high for exactly one system clock each time a right word is captured after a left word. `out_left` and `out_right` change only in the cycle in which `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sdi_bclk | input | 1 | Serial bit clock, asynchronous to clk |
| sdi_lrck | input | 1 | Channel-select clock, asynchronous to clk |
| sdi_data | input | 1 | Serial data, MSB first |
| cfg_i2s | input | 1 | Framing: 0 right-justified, 1 I2S |
| cfg_len18 | input | 1 | Word length: 0 selects 16 bits, 1 selects 18 bits |
| cfg_lr_inv | input | 1 | Channel-select polarity: 0 high means left, 1 low means left |
| out_left | output | 18 | Left sample, sign-extended when 16-bit |
| out_right | output | 18 | Right sample, sign-extended when 16-bit |
| out_valid | output | 1 | One-cycle strobe: a new left/right pair is on the outputs |

## Verification
An off-by-one position in the bit counter or in word extraction shows up as a word shifted by one place, or with a junk bit, on the very first frame after reset. A wrong polarity or a wrong channel bookkeeping flag appears as swapped words or as a missing or extra valid pulse within one sample period. Wrong arming state shows up at the ports as a pulse that comes from the discarded first half-frame. The stimulus mixes half-frames that are exactly one word long, which catches a misplaced I2S LSB, with long half-frames full of random padding, which catches bits that should have been discarded.

// File: rtl/sar_pkg.sv
// Shared definitions for the serial audio receiver.
// Assumes: the defaults below are the widths used by the top module.
package sar_pkg;
    localparam int WORD_LONG  = 18;   // long word length and output width
    localparam int WORD_SHORT = 16;   // short word length
    localparam int SYNC_DEPTH = 2;    // synchronizer flops per input

    typedef enum logic {
        FMT_RJ  = 1'b0,               // LSB ends at channel-select change
        FMT_I2S = 1'b1                // MSB one bit after the change
    } fmt_e;
endpackage

// File: rtl/sar_sync.sv
// Multi-bit synchronizer: each bit passes through DEPTH flops.
// Assumes: each bit is an independent slow level, so no bus coherence is needed.
module sar_sync #(
    parameter int WIDTH = 3,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [DEPTH-1:0] chain;

        // Shift the raw level through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[DEPTH-2:0], async_i[b]};
        end

        assign sync_o[b] = chain[DEPTH-1];
    end
endmodule

// File: rtl/sar_edge.sv
// Rising-edge detector for a synchronized level; one-cycle pulse per edge.
// Assumes: the input is already in the clk domain.
module sar_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic level_q;

    // Remember the previous level to compare against.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/sar_shifter.sv
// Serial-in shift register: keeps the newest W bits, newest in bit 0.
// Assumes: shift_i is a single-cycle strobe per bit-clock rise.
module sar_shifter #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] shreg_o
);
    // Move earlier bits toward the MSB end on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       shreg_o <= '0;
        else if (shift_i) shreg_o <= {shreg_o[W-2:0], bit_i};
    end

    // R2: a strobe moves every bit exactly one place up.
    assert_shift_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> shreg_o[W-1:1] == $past(shreg_o[W-2:0]));
    // R2: with no strobe the stored bits hold.
    assert_hold_without_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(shreg_o));
endmodule

// File: rtl/sar_frame.sv
// Frame tracker: follows channel-select changes at bit-clock rises, chooses the
// capture point for each framing, extracts and sign-extends words, and pairs
// left and right into a valid strobe.
// Assumes: configuration inputs are static outside reset.
module sar_frame #(
    parameter int W_LONG  = 18,
    parameter int W_SHORT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              lr_i,
    input  logic              data_i,
    input  logic [W_LONG-1:0] shreg_i,
    input  logic              cfg_i2s,
    input  logic              cfg_len18,
    input  logic              cfg_lr_inv,
    output logic [W_LONG-1:0] out_left_o,
    output logic [W_LONG-1:0] out_right_o,
    output logic              out_valid_o
);
    import sar_pkg::*;

    localparam int CNT_W = $clog2(W_LONG + 2) + 1;
    localparam logic [CNT_W-1:0] CNT_SAT = '1;
    localparam int EXT_W = W_LONG - W_SHORT;

    sar_pkg::fmt_e     fmt;
    logic              started, armed, lr_prev, have_left;
    logic [CNT_W-1:0]  cnt, pos, n_len;
    logic              boundary, cap, cap_is_left;
    logic [W_LONG-1:0] raw, word, pend_left;

    assign fmt   = sar_pkg::fmt_e'(cfg_i2s);
    assign n_len = cfg_len18 ? CNT_W'(W_LONG) : CNT_W'(W_SHORT);

    // Channel change seen at this bit-clock rise.
    always_comb boundary = started && (lr_i != lr_prev);

    // Position of the current bit within its half-frame, saturating.
    always_comb pos = (cnt == CNT_SAT) ? CNT_SAT : cnt + 1'b1;

    // Capture point and raw word for the selected framing.
    always_comb begin
        if (fmt == FMT_I2S) begin
            cap = rise_i && armed && (pos == n_len);
            raw = {shreg_i[W_LONG-2:0], data_i};
        end else begin
            cap = rise_i && armed && boundary;
            raw = shreg_i;
        end
    end

    // Sign-extend a short word to the output width.
    always_comb begin
        if (cfg_len18) word = raw;
        else           word = {{EXT_W{raw[W_SHORT-1]}}, raw[W_SHORT-1:0]};
    end

    // The captured word belongs to the channel of the previous rise.
    always_comb cap_is_left = lr_prev ^ cfg_lr_inv;

    // Track channel select, half-frame bit count and arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
            armed   <= 1'b0;
            lr_prev <= 1'b0;
            cnt     <= CNT_SAT;
        end else if (rise_i) begin
            started <= 1'b1;
            lr_prev <= lr_i;
            if (boundary) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else begin
                cnt <= pos;
            end
        end
    end

    // Hold the left word and publish pairs with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_left   <= 1'b0;
            pend_left   <= '0;
            out_left_o  <= '0;
            out_right_o <= '0;
            out_valid_o <= 1'b0;
        end else begin
            out_valid_o <= 1'b0;
            if (cap && cap_is_left) begin
                pend_left <= word;
                have_left <= 1'b1;
            end else if (cap && have_left) begin
                out_left_o  <= pend_left;
                out_right_o <= word;
                out_valid_o <= 1'b1;
                have_left   <= 1'b0;
            end
        end
    end

    // R7: the strobe lasts one cycle.
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |=> !out_valid_o);
    // R7: the outputs move only together with the strobe.
    assert_outputs_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> ($stable(out_left_o) && $stable(out_right_o)));
    // R2: a pair is published only after a bit-clock rise.
    assert_valid_follows_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(rise_i));
    // R1: nothing is published before the first channel change.
    assert_no_valid_unarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !out_valid_o);
    // R6: the I2S bit count starts over at every channel change.
    assert_count_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && boundary) |=> (cnt == '0));
endmodule

// File: rtl/serial_audio_rx.sv
// Serial audio input receiver top: synchronizes the three serial wires,
// detects bit-clock rises, shifts data in and frames left/right words.
// Assumes: clk is faster than the bit clock, each bit-clock phase lasts at
// least two clk periods, and the cfg_* inputs change only in reset.
module serial_audio_rx #(
    parameter int WORD_W  = sar_pkg::WORD_LONG,
    parameter int SHORT_W = sar_pkg::WORD_SHORT,
    parameter int SYNC_N  = sar_pkg::SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdi_bclk,
    input  logic              sdi_lrck,
    input  logic              sdi_data,
    input  logic              cfg_i2s,
    input  logic              cfg_len18,
    input  logic              cfg_lr_inv,
    output logic [WORD_W-1:0] out_left,
    output logic [WORD_W-1:0] out_right,
    output logic              out_valid
);
    logic [2:0]        pins_s;
    logic              bclk_rise;
    logic [WORD_W-1:0] shreg;

    sar_sync #(.WIDTH(3), .DEPTH(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi_data, sdi_lrck, sdi_bclk}),
        .sync_o  (pins_s)
    );

    sar_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pins_s[0]),
        .rise_o  (bclk_rise)
    );

    sar_shifter #(.W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (bclk_rise),
        .bit_i   (pins_s[2]),
        .shreg_o (shreg)
    );

    sar_frame #(.W_LONG(WORD_W), .W_SHORT(SHORT_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (bclk_rise),
        .lr_i        (pins_s[1]),
        .data_i      (pins_s[2]),
        .shreg_i     (shreg),
        .cfg_i2s     (cfg_i2s),
        .cfg_len18   (cfg_len18),
        .cfg_lr_inv  (cfg_lr_inv),
        .out_left_o  (out_left),
        .out_right_o (out_right),
        .out_valid_o (out_valid)
    );
endmodule

// File: tb/serial_audio_rx_bench.sv
// Bench: directed corner cases plus seeded random framings, checked against
// words placed in the stream by the bench itself.
module serial_audio_rx_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
    logic c_i2s = 1'b0, c_l18 = 1'b0, c_inv = 1'b0;
    logic [17:0] o_l, o_r;
    logic o_v;

    int n_chk = 0, n_fail = 0;
    int mon_n = 0;
    logic [17:0] mon_l [16];
    logic [17:0] mon_r [16];
    logic [17:0] exp_l [16];
    logic [17:0] exp_r [16];
    logic lr_arr [2048];
    logic d_arr  [2048];

    always #5 clk = ~clk;

    serial_audio_rx u_serial_audio_rx (
        .clk(clk), .rst_n(rst_n), .sdi_bclk(bclk), .sdi_lrck(lrck),
        .sdi_data(sdata), .cfg_i2s(c_i2s), .cfg_len18(c_l18),
        .cfg_lr_inv(c_inv), .out_left(o_l), .out_right(o_r), .out_valid(o_v)
    );

    // Record each published pair away from the active edge.
    always @(negedge clk) begin
        if (rst_n && o_v) begin
            if (mon_n < 16) begin
                mon_l[mon_n] = o_l;
                mon_r[mon_n] = o_r;
            end
            mon_n++;
        end
    end

    function automatic logic [17:0] sext(input logic [17:0] w, input logic l18);
        return l18 ? w : {{2{w[15]}}, w[15:0]};
    endfunction

    task automatic chk(input string req, input string what, input logic [17:0] got,
                       input logic [17:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bclk = 1'b0; lrck = 1'b0; sdata = 1'b0;
        repeat (4) @(negedge clk);
        mon_n = 0;
        rst_n = 1'b1;
    endtask

    // Drive bits [0, nbits) of the stream; data and select change while bclk is low.
    task automatic drive(input int nbits, input int h);
        for (int i = 0; i < nbits; i++) begin
            bclk = 1'b0; lrck = lr_arr[i]; sdata = d_arr[i];
            repeat (h) @(negedge clk);
            bclk = 1'b1;
            repeat (h) @(negedge clk);
        end
        bclk = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    // Build a stream: lead-in right half, frames of left/right, trailing left half.
    task automatic build(input logic i2s, input logic l18, input logic inv,
                         input int slot, input int frames);
        int n = l18 ? 18 : 16;
        int total = slot * (2 * frames + 2);
        logic lv_left = ~inv;
        for (int i = 0; i < total; i++) begin
            int hi = i / slot;
            d_arr[i]  = 1'($urandom);
            lr_arr[i] = (hi == 0) ? ~lv_left : (((hi - 1) % 2 == 0) ? lv_left : ~lv_left);
        end
        for (int f = 0; f < frames; f++) begin
            for (int c = 0; c < 2; c++) begin
                logic [17:0] w = 18'($urandom);
                int st = (1 + 2 * f + c) * slot;
                int base = i2s ? st + 1 : st + slot - n;
                if (!l18) w[17:16] = 2'b00;
                if (f == 0) w[n-1] = (c == 0);   // negative left, positive right
                for (int j = 0; j < n; j++) d_arr[base + j] = w[n-1-j];
                if (c == 0) exp_l[f] = sext(w, l18);
                else        exp_r[f] = sext(w, l18);
            end
        end
    endtask

    task automatic scenario(input string req, input logic i2s, input logic l18,
                            input logic inv, input int slot, input int frames,
                            input int h);
        c_i2s = i2s; c_l18 = l18; c_inv = inv;
        do_reset();
        build(i2s, l18, inv, slot, frames);
        drive(slot * (2 * frames + 2), h);
        chk(req, "pair count", 18'(mon_n), 18'(frames));
        for (int f = 0; f < frames && f < 16 && f < mon_n; f++) begin
            chk(req, $sformatf("left word %0d", f), mon_l[f], exp_l[f]);
            chk(req, $sformatf("right word %0d", f), mon_r[f], exp_r[f]);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_a0d1));
        c_i2s = 1'b0; c_l18 = 1'b0; c_inv = 1'b0;
        do_reset();
        @(negedge clk);
        // R1: reset state
        chk("R1", "valid after reset", 18'(o_v), 18'd0);
        chk("R1", "left after reset", o_l, 18'd0);
        chk("R1", "right after reset", o_r, 18'd0);

        // R1: lead-in, left half and part of right half: no pair yet
        build(1'b0, 1'b0, 1'b0, 16, 1);
        drive(16 * 2 + 8, 2);
        chk("R1", "no pair before a full frame", 18'(mon_n), 18'd0);
        chk("R1", "left held at reset value", o_l, 18'd0);

        // R5 / R3: right-justified, tight and padded half-frames
        scenario("R5_R3_rj16_tight", 1'b0, 1'b0, 1'b0, 16, 3, 2);
        scenario("R5_R3_rj18_tight", 1'b0, 1'b1, 1'b0, 18, 3, 3);
        scenario("R5_rj16_pad32", 1'b0, 1'b0, 1'b0, 32, 3, 2);
        scenario("R5_rj18_pad25", 1'b0, 1'b1, 1'b0, 25, 2, 4);
        // R6: I2S, one spare bit, long padding, LSB past next change
        scenario("R6_i2s16_slot17", 1'b1, 1'b0, 1'b0, 17, 3, 2);
        scenario("R6_i2s18_slot32", 1'b1, 1'b1, 1'b0, 32, 3, 3);
        scenario("R6_i2s16_exact", 1'b1, 1'b0, 1'b0, 16, 3, 2);
        scenario("R6_i2s18_exact", 1'b1, 1'b1, 1'b0, 18, 2, 2);
        // R4: inverted channel-select polarity in both framings
        scenario("R4_rj16_inv", 1'b0, 1'b0, 1'b1, 20, 3, 2);
        scenario("R4_i2s18_inv", 1'b1, 1'b1, 1'b1, 24, 3, 2);
        // R2 / R7: random framings and bit-clock rates
        for (int k = 0; k < 8; k++) begin
            logic ri = 1'($urandom);
            logic rl = 1'($urandom);
            logic rv = 1'($urandom);
            int n = rl ? 18 : 16;
            int sl = n + int'($urandom_range(0, 32 - n));
            scenario($sformatf("R2_R7_rand%0d", k), ri, rl, rv, sl,
                     int'($urandom_range(2, 5)), int'($urandom_range(2, 4)));
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule